// File: doc/BRIEF.md
# Two-Lane Serial Converter Deserializer

This block rebuilds parallel samples from a converter that sends each sample over two serial data lanes. The lanes come with a data clock and a frame clock. The block runs in the data-clock domain. It captures each lane on both data-clock edges or on the rising edge only. It uses the frame clock to find where each sample starts. It then places every captured bit at its position in the sample word, according to the lane packing in use.

The three mode inputs are static configuration. Change them only while reset is asserted. Their all-zero setting selects capture on both edges, single-rate framing and interleaved packing. A finished sample appears on `sample_o` together with a one-cycle `valid_o` pulse. A word that is cut short by a framing fault is dropped, and it sets a sticky flag.

Top module: `dual_lane_deser`

## Requirements
- R1: While `rst_ni` is low and after it is released, `valid_o`, `misalign_o` and `sample_o` read 0 until a sample is decoded.
- R2: With `sdr_i`=0, each lane gives two slots per data clock. The slot captured on the rising edge comes before the slot captured on the following falling edge. A sample may begin in either slot.
- R3: With `sdr_i`=1, each lane gives one slot per data clock, captured on the rising edge. Levels that are present only around the falling edge, on the lanes or on the frame input, have no effect on the output.
- R4: With `bytewise_i`=0 (interleaved), slot k of a sample (k = 0..H-1, where H = SAMPLE_W/2) carries bit SAMPLE_W-1-2k on lane A and bit SAMPLE_W-2-2k on lane B.
- R5: With `bytewise_i`=1 (split), slot k carries bit SAMPLE_W-1-k on lane A and bit H-1-k on lane B. Lane A therefore holds the upper half of the sample and lane B the lower half, each MSB first.
- R6: With `frame2x_i`=0, a rising frame edge starts a sample at the current slot. A rising frame edge is a slot whose frame level is 1 while the slot before it was 0. Falling frame edges have no effect, wherever they fall.
- R7: With `frame2x_i`=1, a sample also starts on a rising frame edge. Its frame level must also fall exactly at slot H/2 and at no other slot. A missing or misplaced falling edge drops the word and sets `misalign_o`.
- R8: `valid_o` is high for one cycle for each complete sample, with the word on `sample_o`. The pulse appears after the first rising data-clock edge that follows the capture of the sample's last slot. `sample_o` holds its value between pulses.
- R9: A rising frame edge that arrives while a sample is incomplete drops the partial word and sets `misalign_o`. A new sample starts at that edge.
- R10: After reset, no word is reported before a rising frame edge is seen. A frame level that is already high when reset is released is not an edge.
- R11: Between samples the block is idle. Slots without a rising frame edge are ignored, so gaps of any length between samples are allowed.
- R12: `misalign_o` stays set until reset, and decoding goes on normally while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock from the converter |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdr_i | input | 1 | 1: rising-edge capture only; 0: capture on both edges |
| bytewise_i | input | 1 | 1: split packing; 0: interleaved packing |
| frame2x_i | input | 1 | 1: double-rate frame checking; 0: single-rate framing |
| lane_a_i | input | 1 | Serial data lane A |
| lane_b_i | input | 1 | Serial data lane B |
| frame_i | input | 1 | Frame clock, sampled like a data lane |
| sample_o | output | SAMPLE_W | Reassembled sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |
| misalign_o | output | 1 | Sticky framing fault flag |

## Verification
The design has one register stage from capture to output. The slots of data-clock cycle c are captured at rising edge c and at the falling edge after it. They are processed at rising edge c+1, so any word they complete is valid during cycle c+1 and no other cycle. The bench stamps each driven cycle and stores, for every expected word, both its value and the cycle count at which it must appear. A monitor samples the outputs on falling edges only. It checks the value and the exact cycle of every strobe, and it flags any strobe that was not expected. The sticky flag is checked after each stream has been flushed with idle cycles. The queue of expected words must also be empty by then.

// File: rtl/dual_lane_deser_pkg.sv
package dual_lane_deser_pkg;

  typedef struct packed {
    logic a;
    logic b;
    logic fco;
  } slot_t;

  typedef enum logic {
    PACK_BITWISE  = 1'b0,
    PACK_BYTEWISE = 1'b1
  } pack_e;

  localparam slot_t SLOT_RESET = '{a: 1'b0, b: 1'b0, fco: 1'b1};

endpackage

// File: rtl/dld_capture.sv
module dld_capture
  import dual_lane_deser_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lane_a_i,
  input  logic  lane_b_i,
  input  logic  frame_i,
  output slot_t rise_o,
  output slot_t fall_o
);

  slot_t rise_q, fall_q;

  // frame level resets high: a frame already high at release is no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= SLOT_RESET;
    else         rise_q <= '{a: lane_a_i, b: lane_b_i, fco: frame_i};
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= SLOT_RESET;
    else         fall_q <= '{a: lane_a_i, b: lane_b_i, fco: frame_i};
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;

endmodule

// File: rtl/dld_lane_map.sv
module dld_lane_map
  import dual_lane_deser_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  localparam int HALF_W  = SAMPLE_W / 2,
  localparam int CNT_W   = (HALF_W > 1) ? $clog2(HALF_W) : 1
) (
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                a_i,
  input  logic                b_i,
  input  pack_e               pack_i,
  input  logic [SAMPLE_W-1:0] word_i,
  output logic [SAMPLE_W-1:0] word_o
);

  always_comb begin
    int k;
    k      = int'(cnt_i);
    word_o = word_i;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (pack_i == PACK_BYTEWISE) begin
        if (i == SAMPLE_W - 1 - k) word_o[i] = a_i;
        if (i == HALF_W - 1 - k)   word_o[i] = b_i;
      end else begin
        if (i == SAMPLE_W - 1 - 2 * k) word_o[i] = a_i;
        if (i == SAMPLE_W - 2 - 2 * k) word_o[i] = b_i;
      end
    end
  end

endmodule

// File: rtl/dld_frame_step.sv
module dld_frame_step
  import dual_lane_deser_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  localparam int HALF_W  = SAMPLE_W / 2,
  localparam int CNT_W   = (HALF_W > 1) ? $clog2(HALF_W) : 1
) (
  input  logic                en_i,
  input  logic                frame2x_i,
  input  pack_e               pack_i,
  input  slot_t               slot_i,
  input  logic                busy_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [SAMPLE_W-1:0] word_i,
  input  logic                prev_i,
  output logic                busy_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [SAMPLE_W-1:0] word_o,
  output logic                prev_o,
  output logic                done_o,
  output logic                err_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_W - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(HALF_W / 2);

  logic                rise, fall, at_mid;
  logic [CNT_W-1:0]    map_cnt;
  logic [SAMPLE_W-1:0] map_base, map_word;

  assign rise     = slot_i.fco & ~prev_i;
  assign fall     = ~slot_i.fco & prev_i;
  assign at_mid   = (cnt_i == MID);
  assign map_cnt  = rise ? '0 : cnt_i;
  assign map_base = rise ? '0 : word_i;

  dld_lane_map #(.SAMPLE_W(SAMPLE_W)) u_map (
    .cnt_i  (map_cnt),
    .a_i    (slot_i.a),
    .b_i    (slot_i.b),
    .pack_i (pack_i),
    .word_i (map_base),
    .word_o (map_word)
  );

  always_comb begin
    busy_o = busy_i;
    cnt_o  = cnt_i;
    word_o = word_i;
    prev_o = prev_i;
    done_o = 1'b0;
    err_o  = 1'b0;
    if (en_i) begin
      prev_o = slot_i.fco;
      if (rise) begin
        // early edge drops the partial word and restarts here
        err_o  = busy_i;
        busy_o = 1'b1;
        cnt_o  = CNT_W'(1);
        word_o = map_word;
      end else if (busy_i) begin
        if (frame2x_i && (fall != at_mid)) begin
          err_o  = 1'b1;
          busy_o = 1'b0;
          cnt_o  = '0;
        end else begin
          word_o = map_word;
          if (cnt_i == LAST) begin
            done_o = 1'b1;
            busy_o = 1'b0;
            cnt_o  = '0;
          end else begin
            cnt_o = cnt_i + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dual_lane_deser.sv
module dual_lane_deser
  import dual_lane_deser_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  localparam int HALF_W  = SAMPLE_W / 2,
  localparam int CNT_W   = (HALF_W > 1) ? $clog2(HALF_W) : 1,
  localparam int N_SLOT  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sdr_i,
  input  logic                bytewise_i,
  input  logic                frame2x_i,
  input  logic                lane_a_i,
  input  logic                lane_b_i,
  input  logic                frame_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o,
  output logic                misalign_o
);

  pack_e pack;
  assign pack = pack_e'(bytewise_i);

  slot_t slot_c [N_SLOT];

  dld_capture u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lane_a_i (lane_a_i),
    .lane_b_i (lane_b_i),
    .frame_i  (frame_i),
    .rise_o   (slot_c[0]),
    .fall_o   (slot_c[1])
  );

  logic                busy_q, prev_q, valid_q, misalign_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SAMPLE_W-1:0] word_q, sample_q;

  logic                busy_c [N_SLOT+1];
  logic                prev_c [N_SLOT+1];
  logic [CNT_W-1:0]    cnt_c  [N_SLOT+1];
  logic [SAMPLE_W-1:0] word_c [N_SLOT+1];
  logic [N_SLOT-1:0]   done_c, err_c;

  assign busy_c[0] = busy_q;
  assign prev_c[0] = prev_q;
  assign cnt_c[0]  = cnt_q;
  assign word_c[0] = word_q;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic en;
    // second slot is the falling-edge capture, used only in DDR
    assign en = (g == 0) ? 1'b1 : ~sdr_i;

    dld_frame_step #(.SAMPLE_W(SAMPLE_W)) u_step (
      .en_i      (en),
      .frame2x_i (frame2x_i),
      .pack_i    (pack),
      .slot_i    (slot_c[g]),
      .busy_i    (busy_c[g]),
      .cnt_i     (cnt_c[g]),
      .word_i    (word_c[g]),
      .prev_i    (prev_c[g]),
      .busy_o    (busy_c[g+1]),
      .cnt_o     (cnt_c[g+1]),
      .word_o    (word_c[g+1]),
      .prev_o    (prev_c[g+1]),
      .done_o    (done_c[g]),
      .err_o     (err_c[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      prev_q     <= 1'b1;
      cnt_q      <= '0;
      word_q     <= '0;
      valid_q    <= 1'b0;
      sample_q   <= '0;
      misalign_q <= 1'b0;
    end else begin
      busy_q     <= busy_c[N_SLOT];
      prev_q     <= prev_c[N_SLOT];
      cnt_q      <= cnt_c[N_SLOT];
      word_q     <= word_c[N_SLOT];
      valid_q    <= |done_c;
      misalign_q <= misalign_q | (|err_c);
      if (|done_c) sample_q <= done_c[0] ? word_c[1] : word_c[N_SLOT];
    end
  end

  assign sample_o   = sample_q;
  assign valid_o    = valid_q;
  assign misalign_o = misalign_q;

  AST_MISALIGN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> misalign_o); // R12

  AST_SAMPLE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o)); // R8

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0) && (int'(cnt_q) < HALF_W)); // R11

  if (HALF_W > 2) begin : g_long_sample
    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $past(busy_q)); // R10

    AST_DROP_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(misalign_o) |-> !valid_o); // R9
  end

endmodule

// File: tb/dual_lane_deser_tb_top.sv
`timescale 1ns/1ps
module dual_lane_deser_tb_top;

  localparam int W    = 12;
  localparam int H    = W / 2;
  localparam int NS   = 200;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sdr, byt, f2x;
  logic la, lb, fr;
  logic [W-1:0] sample;
  logic valid, misalign;

  always #2.5 clk = ~clk;

  dual_lane_deser #(.SAMPLE_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sdr_i(sdr), .bytewise_i(byt),
    .frame2x_i(f2x), .lane_a_i(la), .lane_b_i(lb), .frame_i(fr),
    .sample_o(sample), .valid_o(valid), .misalign_o(misalign)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string tag = "R1";

  logic [2:0] sq[$];
  int         se[$];
  int         exp_w[$];
  int         exp_c[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      finish_run();
    end
  end

  // monitor: every strobe must match the next expected word and cycle
  always @(negedge clk) begin
    if (rst_ni && valid) begin
      if (exp_w.size() == 0) begin
        check(1'b0, {tag, " unexpected word"}, int'(sample), -1);
      end else begin
        int ew, ec;
        ew = exp_w.pop_front();
        ec = exp_c.pop_front();
        check(int'(sample) == ew, {tag, " word"}, int'(sample), ew);
        check(cyc == ec, {tag, " strobe cycle"}, cyc, ec);
      end
    end
  end

  function automatic logic [1:0] lane_bits(input int v, input int k, input logic bw);
    logic [W-1:0] x;
    x = W'(v);
    if (bw) return {x[W-1-k], x[H-1-k]};
    return {x[W-1-2*k], x[W-2-2*k]};
  endfunction

  // push n slots of word v; frame level of slot k is fmask[k]
  task automatic add_custom(input int v, input int n, input int fmask, input bit expect_it);
    for (int k = 0; k < n; k++) begin
      logic [1:0] ab;
      ab = lane_bits(v, k, byt);
      sq.push_back({ab, fmask[k]});
      se.push_back((expect_it && k == H - 1) ? v : -1);
    end
  endtask

  task automatic add_sample(input int v, input int hi, input bit expect_it);
    int m;
    m = f2x ? ((1 << (H / 2)) - 1) : ((1 << hi) - 1);
    add_custom(v, H, m, expect_it);
  endtask

  task automatic add_idle(input int n);
    for (int k = 0; k < n; k++) begin
      sq.push_back({k[0], ~k[0], 1'b0});
      se.push_back(-1);
    end
  endtask

  task automatic drive_cycle(input logic [2:0] r, input logic [2:0] f, output int stamp);
    @(negedge clk);
    #1 {la, lb, fr} = r;
    @(posedge clk);
    #1 stamp = cyc;
    {la, lb, fr} = f;
  endtask

  task automatic run_slots();
    while (sq.size() > 0) begin
      logic [2:0] r, f;
      int re, fe, st;
      r  = sq.pop_front();
      re = se.pop_front();
      fe = -1;
      if (sdr) f = ~r;  // falling-edge garbage must be ignored (R3)
      else if (sq.size() > 0) begin
        f  = sq.pop_front();
        fe = se.pop_front();
      end else f = 3'b000;
      drive_cycle(r, f, st);
      if (re >= 0) begin exp_w.push_back(re); exp_c.push_back(st + 1); end
      if (fe >= 0) begin exp_w.push_back(fe); exp_c.push_back(st + 1); end
    end
  endtask

  task automatic flush(input string req);
    add_idle(6);
    run_slots();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(exp_w.size() == 0, {req, " all words delivered"}, exp_w.size(), 0);
    exp_w.delete();
    exp_c.delete();
  endtask

  task automatic do_reset(input logic fr_lvl);
    @(negedge clk);
    rst_ni = 1'b0;
    {la, lb, fr} = {2'b00, fr_lvl};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  function automatic int sweep_val(input int s);
    if (s < W) return 1 << s;
    if (s == W) return 0;
    if (s == W + 1) return (1 << W) - 1;
    return (s * 1237 + 91) & ((1 << W) - 1);
  endfunction

  initial begin
    sdr = 1'b0; byt = 1'b0; f2x = 1'b0;
    la = 1'b0; lb = 1'b0; fr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(valid == 1'b0, "R1 valid in reset", valid, 0);
    check(misalign == 1'b0, "R1 misalign in reset", misalign, 0);
    check(sample == '0, "R1 sample in reset", sample, 0);
    do_reset(1'b0);
    repeat (2) @(negedge clk);
    check(valid == 1'b0 && misalign == 1'b0 && sample == '0, "R1 after release",
          {sample, valid, misalign}, 0);

    // sweep all eight mode combinations, varying duty, gaps and start phase
    for (int m = 0; m < 8; m++) begin
      sdr = m[0]; byt = m[1]; f2x = m[2];
      tag = $sformatf("%s %s %s R8 R11", sdr ? "R3" : "R2", byt ? "R5" : "R4",
                      f2x ? "R7" : "R6");
      do_reset(1'b0);
      add_idle(3);
      for (int s = 0; s < NS; s++) begin
        add_sample(sweep_val(s), (s % (H - 1)) + 1, 1'b1);
        add_idle(s % 3);
      end
      run_slots();
      flush(tag);
      check(misalign == 1'b0, {tag, " no false fault"}, misalign, 0);
    end

    // R6: single-rate frame held high for the whole sample is still fine
    sdr = 1'b0; byt = 1'b0; f2x = 1'b0;
    tag = "R6 long frame";
    do_reset(1'b0);
    add_idle(1);
    add_custom(12'hA5C, H, (1 << H) - 1, 1'b1);
    add_idle(1);
    add_sample(12'h3E1, 2, 1'b1);
    run_slots();
    flush(tag);
    check(misalign == 1'b0, "R6 no fault", misalign, 0);

    // R9: early rising edge drops the partial word, new sample starts there
    tag = "R9 early edge";
    do_reset(1'b0);
    add_idle(2);
    add_custom(12'h5A5, 3, 1, 1'b0);
    add_sample(12'h3C3, 1, 1'b1);
    run_slots();
    flush(tag);
    check(misalign == 1'b1, "R9 fault flagged", misalign, 1);

    // R12: flag stays set, decoding continues
    tag = "R12 after fault";
    add_sample(12'h123, 3, 1'b1);
    add_sample(12'hFED, 1, 1'b1);
    run_slots();
    flush(tag);
    check(misalign == 1'b1, "R12 flag sticky", misalign, 1);

    // R7: double-rate framing with misplaced falling edge
    sdr = 1'b1; byt = 1'b1; f2x = 1'b1;
    tag = "R7 misplaced fall";
    do_reset(1'b0);
    add_idle(2);
    add_custom(12'h777, H, 3, 1'b0);
    add_idle(1);
    add_sample(12'h9B2, 0, 1'b1);
    run_slots();
    flush(tag);
    check(misalign == 1'b1, "R7 misplaced fall flagged", misalign, 1);

    // R7: double-rate framing with no falling edge
    sdr = 1'b0; byt = 1'b0;
    tag = "R7 missing fall";
    do_reset(1'b0);
    add_idle(2);
    add_custom(12'h0F0, H, (1 << H) - 1, 1'b0);
    add_idle(1);
    add_sample(12'h6D4, 0, 1'b1);
    run_slots();
    flush(tag);
    check(misalign == 1'b1, "R7 missing fall flagged", misalign, 1);

    // R10: frame high across reset release is not an edge
    sdr = 1'b0; byt = 1'b0; f2x = 1'b0;
    tag = "R10 no edge at release";
    do_reset(1'b1);
    add_custom(12'hBAD, 3, 7, 1'b0);
    add_idle(1);
    add_sample(12'h482, 3, 1'b1);
    run_slots();
    flush(tag);
    check(misalign == 1'b0, "R10 no fault", misalign, 0);

    finish_run();
  end

endmodule